// File: doc/BRIEF.md
# Serial Transmitter Error Abort Controller

This block holds the error state of a serial frame transmitter that works either with bit-oriented frames closed by an end-of-frame sequence or on a shared medium with carrier sense and collision detection. It keeps three sticky error flags: collision, transmit-FIFO underrun and missing acknowledge. The OR of these flags is the transmit-error interrupt. When an error appears while a frame is being sent, the block aborts the frame. It drops the transmit enable, marks the transmission done, suppresses the CRC for that frame and requests the line behaviour that ends the frame in the active mode.

Software cannot write the flags. The only way to clear them is to write 1 to the transmit enable, which also starts the next frame. On the shared medium, a collision counts as an error only once the frame has touched the transmit FIFO, or when the collision makes the internal collision counter wrap. The serializer, the CRC generator and the FIFO are outside this block. They consume the abort outputs and supply the event pulses.

Top module: `txerr_abort_ctrl`

## Requirements
- R1: After a synchronous reset, every output is 0: the three flags, tx_en, err_irq, tx_done, crc_suppress, eof_req and line_hold_hi.
- R2: A one-cycle pulse on urun_evt or noack_evt sets err_urun or err_noack on the next clock edge. The flag then stays set whatever its event input does later.
- R3: A cycle with en_wr=1 and en_wdata=1 clears all three flags, tx_done, line_hold_hi, the FIFO-accessed mark and the collision counter, and sets tx_en. Clearing wins: an error event in that same cycle is ignored. A write of 0 clears tx_en and leaves the flags unchanged.
- R4: err_irq equals the OR of the three flags in every cycle. An error event forces tx_en to 0 on the same edge that sets its flag.
- R5: An error event in a cycle where tx_en is 1 is an abort. It sets tx_done, which stays set until the next enable write of 1, and it raises crc_suppress for exactly one cycle.
- R6: mode selects the end-of-frame behaviour, with 0 for the end-of-frame-sequence mode and 1 for the shared-medium mode. An abort in mode 0 raises eof_req for exactly one cycle. An abort in mode 1 sets line_hold_hi, which stays set until the next enable write of 1.
- R7: err_coll can be set only by a coll_evt in a cycle with mode=1 and tx_en=1. The FIFO must also have been accessed, either in that cycle or in an earlier cycle of the same frame while tx_en was 1.
- R8: Every coll_evt with mode=1 and tx_en=1 advances a CCNT_W-bit collision counter. A collision that wraps the counter from its maximum value to 0 sets err_coll even if the FIFO was never accessed.
- R9: An error event while tx_en is 0 still sets its flag and err_irq, but leaves tx_done, crc_suppress, eof_req and line_hold_hi unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Software write strobe for the transmit enable |
| en_wdata | input | 1 | Value written to the transmit enable |
| mode | input | 1 | 0 = end-of-frame-sequence mode, 1 = shared-medium collision mode |
| coll_evt | input | 1 | Collision seen on the line (pulse) |
| fifo_acc | input | 1 | Transmit FIFO was accessed (pulse) |
| urun_evt | input | 1 | Transmit FIFO underrun (pulse) |
| noack_evt | input | 1 | Acknowledge missing (pulse) |
| err_coll | output | 1 | Sticky collision error flag |
| err_urun | output | 1 | Sticky underrun error flag |
| err_noack | output | 1 | Sticky no-acknowledge error flag |
| tx_en | output | 1 | Transmit enable |
| err_irq | output | 1 | Transmit-error interrupt level |
| tx_done | output | 1 | Transmission done after an abort |
| crc_suppress | output | 1 | One-cycle request to drop the CRC of the aborted frame |
| eof_req | output | 1 | One-cycle end-of-frame request (mode 0) |
| line_hold_hi | output | 1 | Hold the transmit data line at 1 (mode 1) |

## Verification
The bench builds the block with CCNT_W=2, so the collision counter wraps after four qualified collisions. The wrap path of R8 is therefore reachable in a handful of cycles and comes up often during random traffic. At that width the bench can apply all 128 combinations of the seven control inputs, both with and without an earlier FIFO access in the frame. This covers every clear-versus-event collision and every mode-dependent abort outcome against an arithmetic model.

// File: rtl/txerr_pkg.sv
package txerr_pkg;
  typedef enum logic {
    MODE_SDLC = 1'b0,
    MODE_CSMA = 1'b1
  } tx_mode_e;

  localparam int NUM_ERR = 3;
  localparam int IDX_NOACK = 0;
  localparam int IDX_URUN  = 1;
  localparam int IDX_COLL  = 2;

  typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/txerr_coll_qual.sv
module txerr_coll_qual
  import txerr_pkg::*;
#(
  parameter int CCNT_W = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     tx_en,
  input  tx_mode_e mode,
  input  logic     coll_evt,
  input  logic     fifo_acc,
  output logic     coll_set
);
  localparam logic [CCNT_W-1:0] CNT_MAX = {CCNT_W{1'b1}};

  logic [CCNT_W-1:0] cnt;
  logic              fifo_seen;
  logic              qual;
  logic              wrap;

  assign qual     = tx_en && (mode == MODE_CSMA) && coll_evt;
  assign wrap     = qual && (cnt == CNT_MAX);
  assign coll_set = qual && (fifo_seen || fifo_acc || wrap);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt       <= '0;
      fifo_seen <= 1'b0;
    end else begin
      if (qual)
        cnt <= cnt + CCNT_W'(1);
      if (tx_en && fifo_acc)
        fifo_seen <= 1'b1;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (qual && !clr) |=> (cnt == $past(cnt) + CCNT_W'(1))); // R8

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!qual && !clr) |=> $stable(cnt)); // R8
endmodule

// File: rtl/txerr_flags.sv
module txerr_flags #(
  parameter int NUM_ERR = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [NUM_ERR-1:0] set_vec,
  output logic [NUM_ERR-1:0] flags,
  output logic               irq,
  output logic               new_err
);
  assign new_err = !clr && (|set_vec);

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr)
        flags[i] <= 1'b0;
      else if (set_vec[i])
        flags[i] <= 1'b1;
    end

    AST_FLAG_CLEAR_ONLY_BY_ENABLE: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[i]) |-> $past(clr)); // R3
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      irq <= 1'b0;
    else
      irq <= (|flags) | (|set_vec);
  end

  AST_IRQ_IS_FLAG_OR: assert property (@(posedge clk) disable iff (rst)
    irq == (|flags)); // R4
endmodule

// File: rtl/txerr_abort_seq.sv
module txerr_abort_seq
  import txerr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     en_wr,
  input  logic     new_err,
  input  tx_mode_e mode,
  output logic     tx_en,
  output logic     tx_done,
  output logic     crc_suppress,
  output logic     eof_req,
  output logic     line_hold_hi
);
  logic abort;

  assign abort = new_err && tx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en        <= 1'b0;
      tx_done      <= 1'b0;
      crc_suppress <= 1'b0;
      eof_req      <= 1'b0;
      line_hold_hi <= 1'b0;
    end else if (clr) begin
      tx_en        <= 1'b1;
      tx_done      <= 1'b0;
      crc_suppress <= 1'b0;
      eof_req      <= 1'b0;
      line_hold_hi <= 1'b0;
    end else begin
      crc_suppress <= abort;
      eof_req      <= abort && (mode == MODE_SDLC);
      if (abort && (mode == MODE_CSMA))
        line_hold_hi <= 1'b1;
      if (abort)
        tx_done <= 1'b1;
      if (new_err || en_wr)
        tx_en <= 1'b0;
    end
  end

  AST_CRC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    crc_suppress |=> !crc_suppress); // R5

  AST_DONE_WITH_CRC: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> crc_suppress); // R5

  AST_EOF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    eof_req |=> !eof_req); // R6

  AST_EOF_NOT_HELD: assert property (@(posedge clk) disable iff (rst)
    eof_req |-> !line_hold_hi); // R6
endmodule

// File: rtl/txerr_abort_ctrl.sv
module txerr_abort_ctrl
  import txerr_pkg::*;
#(
  parameter int CCNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic mode,
  input  logic coll_evt,
  input  logic fifo_acc,
  input  logic urun_evt,
  input  logic noack_evt,
  output logic err_coll,
  output logic err_urun,
  output logic err_noack,
  output logic tx_en,
  output logic err_irq,
  output logic tx_done,
  output logic crc_suppress,
  output logic eof_req,
  output logic line_hold_hi
);
  tx_mode_e mode_e;
  logic     clr;
  logic     coll_set;
  logic     new_err;
  err_vec_t set_vec;
  err_vec_t flags;

  assign mode_e = tx_mode_e'(mode);
  assign clr    = en_wr && en_wdata;

  txerr_coll_qual #(.CCNT_W(CCNT_W)) u_coll (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .tx_en    (tx_en),
    .mode     (mode_e),
    .coll_evt (coll_evt),
    .fifo_acc (fifo_acc),
    .coll_set (coll_set)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[IDX_COLL]  = coll_set;
    set_vec[IDX_URUN]  = urun_evt;
    set_vec[IDX_NOACK] = noack_evt;
  end

  txerr_flags #(.NUM_ERR(NUM_ERR)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .set_vec (set_vec),
    .flags   (flags),
    .irq     (err_irq),
    .new_err (new_err)
  );

  txerr_abort_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .clr          (clr),
    .en_wr        (en_wr),
    .new_err      (new_err),
    .mode         (mode_e),
    .tx_en        (tx_en),
    .tx_done      (tx_done),
    .crc_suppress (crc_suppress),
    .eof_req      (eof_req),
    .line_hold_hi (line_hold_hi)
  );

  assign err_coll  = flags[IDX_COLL];
  assign err_urun  = flags[IDX_URUN];
  assign err_noack = flags[IDX_NOACK];

  AST_IRQ_BLOCKS_EN: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> !tx_en); // R4

  AST_COLL_CSMA_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(err_coll) |-> ($past(mode) && $past(tx_en) && $past(coll_evt))); // R7

  AST_URUN_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(err_urun) |-> $past(urun_evt)); // R2

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_done)) |-> $past(tx_en)); // R9
endmodule

// File: tb/tb_txerr_abort_ctrl.sv
module tb_txerr_abort_ctrl;
  localparam int CW   = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_wr = 0, en_wdata = 0, mode = 0, coll_evt = 0, fifo_acc = 0, urun_evt = 0, noack_evt = 0;
  logic err_coll, err_urun, err_noack, tx_en, err_irq, tx_done, crc_suppress, eof_req, line_hold_hi;

  int checks = 0;
  int failures = 0;

  logic m_coll, m_urun, m_noack, m_en, m_done, m_crc, m_eof, m_hold, m_fseen;
  int   m_cnt;

  always #4 clk = ~clk;

  txerr_abort_ctrl #(.CCNT_W(CW)) dut (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata), .mode(mode),
    .coll_evt(coll_evt), .fifo_acc(fifo_acc), .urun_evt(urun_evt), .noack_evt(noack_evt),
    .err_coll(err_coll), .err_urun(err_urun), .err_noack(err_noack), .tx_en(tx_en),
    .err_irq(err_irq), .tx_done(tx_done), .crc_suppress(crc_suppress),
    .eof_req(eof_req), .line_hold_hi(line_hold_hi)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R7", "err_coll",     err_coll,     m_coll);
    chk("R2", "err_urun",     err_urun,     m_urun);
    chk("R2", "err_noack",    err_noack,    m_noack);
    chk("R3", "tx_en",        tx_en,        m_en);
    chk("R4", "err_irq",      err_irq,      m_coll | m_urun | m_noack);
    chk("R5", "tx_done",      tx_done,      m_done);
    chk("R5", "crc_suppress", crc_suppress, m_crc);
    chk("R6", "eof_req",      eof_req,      m_eof);
    chk("R6", "line_hold_hi", line_hold_hi, m_hold);
  endtask

  task automatic model_reset();
    m_coll = 0; m_urun = 0; m_noack = 0; m_en = 0; m_done = 0;
    m_crc = 0; m_eof = 0; m_hold = 0; m_fseen = 0; m_cnt = 0;
  endtask

  // Drive one cycle of inputs at the falling edge, update the model, check at the next falling edge.
  task automatic step(input logic wr, input logic wd, input logic md, input logic co,
                      input logic fi, input logic ur, input logic na);
    logic clr, qual, wrap, sc, newerr, abort, old_en;
    en_wr = wr; en_wdata = wd; mode = md; coll_evt = co; fifo_acc = fi;
    urun_evt = ur; noack_evt = na;
    old_en = m_en;
    clr    = wr & wd;
    qual   = old_en & md & co;
    wrap   = qual && (m_cnt == CMAX);
    sc     = qual && (m_fseen || fi || wrap);
    newerr = !clr && (sc || ur || na);
    abort  = newerr && old_en;
    if (clr) begin
      m_coll = 0; m_urun = 0; m_noack = 0; m_en = 1; m_done = 0;
      m_crc = 0; m_eof = 0; m_hold = 0; m_fseen = 0; m_cnt = 0;
    end else begin
      m_coll  = m_coll | sc;
      m_urun  = m_urun | ur;
      m_noack = m_noack | na;
      m_crc   = abort;
      m_eof   = abort && !md;
      m_hold  = m_hold | (abort && md);
      m_done  = m_done | abort;
      m_en    = (newerr || wr) ? 1'b0 : old_en;
      m_fseen = m_fseen | (old_en && fi);
      if (qual) m_cnt = (m_cnt + 1) & CMAX;
    end
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input logic md);
    step(0, 0, md, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: every output is low after reset
    chk("R1", "err_coll",     err_coll,     0);
    chk("R1", "err_urun",     err_urun,     0);
    chk("R1", "err_noack",    err_noack,    0);
    chk("R1", "tx_en",        tx_en,        0);
    chk("R1", "err_irq",      err_irq,      0);
    chk("R1", "tx_done",      tx_done,      0);
    chk("R1", "crc_suppress", crc_suppress, 0);
    chk("R1", "eof_req",      eof_req,      0);
    chk("R1", "line_hold_hi", line_hold_hi, 0);

    // R9: an error with the enable low sets the flag only
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R9", "err_urun idle", err_urun, 1);
    chk("R9", "tx_done idle",  tx_done,  0);
    chk("R9", "crc idle",      crc_suppress, 0);
    idle(0);

    // R3: the enable write clears the flags and beats a same-cycle error
    step(1, 1, 0, 0, 0, 0, 1);
    chk("R3", "err_noack clear wins", err_noack, 0);
    chk("R3", "err_urun cleared",     err_urun,  0);
    chk("R3", "tx_en set",            tx_en,     1);

    // R8: collisions without FIFO access set the flag only when the counter wraps
    step(1, 1, 1, 0, 0, 0, 0);
    for (int k = 0; k < CMAX; k++) begin
      step(0, 0, 1, 1, 0, 0, 0);
      chk("R8", "err_coll before wrap", err_coll, 0);
    end
    step(0, 0, 1, 1, 0, 0, 0);
    chk("R8", "err_coll on wrap", err_coll, 1);
    chk("R6", "line_hold_hi csma abort", line_hold_hi, 1);
    chk("R4", "tx_en dropped", tx_en, 0);
    idle(1);

    // R7: a collision after FIFO access in shared-medium mode sets the flag at once
    step(1, 1, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0, 0);
    chk("R7", "err_coll after fifo access", err_coll, 1);

    // Exhaustive sweep of all input combinations, with and without prior FIFO access
    for (int pre = 0; pre < 2; pre++) begin
      for (int c = 0; c < 128; c++) begin
        logic [6:0] v;
        v = 7'(c);
        step(1, 1, v[4], 0, 0, 0, 0);
        if (pre == 1) step(0, 0, v[4], 0, 1, 0, 0);
        step(v[6], v[5], v[4], v[3], v[2], v[1], v[0]);
        idle(v[4]);
      end
    end

    // Random traffic with sparse events
    for (int n = 0; n < 4000; n++) begin
      logic wr, wd, md, co, fi, ur, na;
      wr = ($urandom_range(0, 11) == 0);
      wd = $urandom_range(0, 3) != 0;
      md = ($urandom_range(0, 63) == 0) ? ~mode : mode;
      co = ($urandom_range(0, 5) == 0);
      fi = ($urandom_range(0, 7) == 0);
      ur = ($urandom_range(0, 29) == 0);
      na = ($urandom_range(0, 29) == 0);
      step(wr, wd, md, co, fi, ur, na);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule